// File: doc/BRIEF.md
# Fetch Mask Predictor

This block decides, before a cache line is read, which instruction words of that line the fetch stage will actually consume. Words that are not enabled are not read, which saves array energy. The fetch path supplies the index of the next line. When the next fetch address is a redirect from the target buffer, it also supplies the word offset where execution enters the line. The block returns one enable bit per word.

Two effects trim the line. An entry point in the middle of the line makes the words before it useless. A predicted-taken branch inside the line makes the words after it useless. The entry offset comes from the caller. The branch position comes from a small direct-indexed table that this block owns. The table is written on every branch predictor update, including the updates that follow a detected misprediction.

Each table entry is a two-state machine. `ENT_FULL` means no branch is known and the whole line is fetched. `ENT_CUT` means a taken branch is known at a stored word position. A taken update moves an entry to `ENT_CUT` from either state and loads the position. A not-taken or cleared update moves it to `ENT_FULL` from either state. Reset puts every entry in `ENT_FULL`. With no update, an entry holds its state.

Top module: `fetch_mask_pred`

## Requirements
- R1: After reset, every line index with no target offset gives an all-ones mask.
- R2: With `pred_tgt_vld`=1 and an entry in `ENT_FULL`, mask bit i is 1 exactly when i >= `pred_tgt_off`.
- R3: After a taken update (`upd_taken`=1) at position p for a line, that line with no target gives mask bits 0 through p set and all higher bits clear. With p = WORDS-1, this is all ones.
- R4: When a target and a stored branch both apply and the branch position is not below the offset, the mask is the bitwise AND of the two masks: bits from the offset through the branch position.
- R5: When the stored branch position is below the target offset, the mask has only the target word's bit set.
- R6: A not-taken update (`upd_vld`=1, `upd_taken`=0) returns that line's entry to full-line fetch.
- R7: An update changes only the entry whose index it carries.
- R8: The mask is combinational from the current inputs and table contents. A table write appears only after the next rising clock edge, so in the update cycle itself the mask still reflects the old entry.
- R9: A later taken update to the same line replaces the stored branch position.
- R10: The mask is never all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_line_idx | input | IDX_W | Table index of the next line to fetch |
| pred_tgt_vld | input | 1 | Next fetch address is a taken target inside the line |
| pred_tgt_off | input | OFF_W | Word offset of that target within the line |
| upd_vld | input | 1 | Branch predictor update strobe |
| upd_line_idx | input | IDX_W | Table index the update refers to |
| upd_taken | input | 1 | 1: taken branch at `upd_pos`; 0: not taken or cleared |
| upd_pos | input | OFF_W | Word position of the taken branch |
| fetch_mask | output | WORDS | Per-word enable, bit i for word i |

## Verification
The bench looks up a line in the same cycle that the line is being updated. A design that forwarded the write, or one that registered the mask, would fail this check. It tests a branch that lies before the target offset. Here a plain AND would give an empty mask and the fetch would stall. It runs the boundary positions 0 and WORDS-1 for both the target and the branch, where an off-by-one in the range compare trims or keeps the wrong edge word. Overwrites, clears and a neighbouring line are also checked, so that a design that ignored the update index or kept a stale position would be caught.

// File: rtl/fmp_pkg.sv
package fmp_pkg;
    typedef enum logic {
        ENT_FULL = 1'b0,
        ENT_CUT  = 1'b1
    } ent_state_e;
endpackage

// File: rtl/fmp_table.sv
module fmp_table
    import fmp_pkg::*;
#(
    parameter int LINES = 16,
    parameter int WORDS = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_vld,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_taken,
    input  logic [OFF_W-1:0] upd_pos,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_cut,
    output logic [OFF_W-1:0] rd_pos
);
    ent_state_e       st_q   [LINES];
    ent_state_e       st_nxt [LINES];
    logic [OFF_W-1:0] pos_q  [LINES];

    // next-state per entry
    always_comb begin
        for (int e = 0; e < LINES; e++) begin
            st_nxt[e] = st_q[e];
            if (upd_vld && upd_idx == IDX_W'(e)) begin
                unique case (st_q[e])
                    ENT_FULL: st_nxt[e] = upd_taken ? ENT_CUT : ENT_FULL;
                    ENT_CUT:  st_nxt[e] = upd_taken ? ENT_CUT : ENT_FULL;
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        for (int e = 0; e < LINES; e++) begin
            if (!rst_n) begin
                st_q[e]  <= ENT_FULL;
                pos_q[e] <= '0;
            end else begin
                st_q[e] <= st_nxt[e];
                if (upd_vld && upd_taken && upd_idx == IDX_W'(e))
                    pos_q[e] <= upd_pos;
            end
        end
    end

    // outputs
    always_comb begin
        rd_pos = pos_q[rd_idx];
        unique case (st_q[rd_idx])
            ENT_FULL: rd_cut = 1'b0;
            ENT_CUT:  rd_cut = 1'b1;
        endcase
    end

    // R3 / R9: a taken update lands in its entry on the next edge
    a_r3_taken_write: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_vld && upd_taken) |=>
            (st_q[$past(upd_idx)] == ENT_CUT && pos_q[$past(upd_idx)] == $past(upd_pos)));

    // R6: a not-taken update restores full fetch
    a_r6_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_vld && !upd_taken) |=> (st_q[$past(upd_idx)] == ENT_FULL));
endmodule

// File: rtl/fmp_mask_gen.sv
module fmp_mask_gen #(
    parameter int WORDS = 8,
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             tgt_vld,
    input  logic [OFF_W-1:0] tgt_off,
    input  logic             br_cut,
    input  logic [OFF_W-1:0] br_pos,
    output logic [WORDS-1:0] start_m,
    output logic [WORDS-1:0] end_m
);
    for (genvar i = 0; i < WORDS; i++) begin : g_word
        assign start_m[i] = !tgt_vld || (OFF_W'(i) >= tgt_off);
        assign end_m[i]   = !br_cut  || (OFF_W'(i) <= br_pos);
    end
endmodule

// File: rtl/fetch_mask_pred.sv
module fetch_mask_pred #(
    parameter int LINES = 16,
    parameter int WORDS = 8,
    localparam int IDX_W = $clog2(LINES),
    localparam int OFF_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] pred_line_idx,
    input  logic             pred_tgt_vld,
    input  logic [OFF_W-1:0] pred_tgt_off,
    input  logic             upd_vld,
    input  logic [IDX_W-1:0] upd_line_idx,
    input  logic             upd_taken,
    input  logic [OFF_W-1:0] upd_pos,
    output logic [WORDS-1:0] fetch_mask
);
    logic             br_cut;
    logic [OFF_W-1:0] br_pos;
    logic [WORDS-1:0] start_m;
    logic [WORDS-1:0] end_m;
    logic [WORDS-1:0] both_m;

    fmp_table #(.LINES(LINES), .WORDS(WORDS)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_vld   (upd_vld),
        .upd_idx   (upd_line_idx),
        .upd_taken (upd_taken),
        .upd_pos   (upd_pos),
        .rd_idx    (pred_line_idx),
        .rd_cut    (br_cut),
        .rd_pos    (br_pos)
    );

    fmp_mask_gen #(.WORDS(WORDS)) u_gen (
        .tgt_vld (pred_tgt_vld),
        .tgt_off (pred_tgt_off),
        .br_cut  (br_cut),
        .br_pos  (br_pos),
        .start_m (start_m),
        .end_m   (end_m)
    );

    always_comb begin
        both_m = start_m & end_m;
        if (both_m == '0)
            fetch_mask = WORDS'(1) << pred_tgt_off;
        else
            fetch_mask = both_m;
    end

    // R10: fetch always makes progress
    a_r10_mask_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_mask != '0);

    // R2 / R5: the target word is always enabled
    a_r2_tgt_word_on: assert property (@(posedge clk) disable iff (!rst_n)
        pred_tgt_vld |-> fetch_mask[pred_tgt_off]);

    // R4: nothing below the entry point is fetched
    a_r4_below_tgt_off: assert property (@(posedge clk) disable iff (!rst_n)
        pred_tgt_vld |-> ((fetch_mask & ~start_m) == '0));

    // R3: nothing past a known branch is fetched unless the branch precedes the target
    a_r3_past_branch_off: assert property (@(posedge clk) disable iff (!rst_n)
        (br_cut && !(pred_tgt_vld && br_pos < pred_tgt_off)) |-> ((fetch_mask & ~end_m) == '0));
endmodule

// File: tb/fetch_mask_pred_bench.sv
module fetch_mask_pred_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pred_line_idx = '0;
    logic       pred_tgt_vld = 1'b0;
    logic [2:0] pred_tgt_off = '0;
    logic       upd_vld = 1'b0;
    logic [3:0] upd_line_idx = '0;
    logic       upd_taken = 1'b0;
    logic [2:0] upd_pos = '0;
    logic [7:0] fetch_mask;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fetch_mask_pred u_fetch_mask_pred (
        .clk(clk), .rst_n(rst_n),
        .pred_line_idx(pred_line_idx), .pred_tgt_vld(pred_tgt_vld),
        .pred_tgt_off(pred_tgt_off), .upd_vld(upd_vld),
        .upd_line_idx(upd_line_idx), .upd_taken(upd_taken),
        .upd_pos(upd_pos), .fetch_mask(fetch_mask)
    );

    task automatic look(input logic [3:0] idx, input logic tv, input logic [2:0] off,
                        input logic [7:0] exp, input string req);
        pred_line_idx = idx; pred_tgt_vld = tv; pred_tgt_off = off;
        #1;
        checks++;
        if (fetch_mask !== exp) begin
            errors++;
            $display("FAIL %s line=%0d tgt=%0b off=%0d got=%h exp=%h", req, idx, tv, off, fetch_mask, exp);
        end
    endtask

    // drive update at negedge, write happens at the next posedge
    task automatic upd(input logic [3:0] idx, input logic tk, input logic [2:0] p);
        @(negedge clk);
        upd_vld = 1'b1; upd_line_idx = idx; upd_taken = tk; upd_pos = p;
        @(negedge clk);
        upd_vld = 1'b0;
    endtask

    task automatic t_reset();
        look(4'd0, 0, 3'd0, 8'hFF, "R1");
        look(4'd5, 0, 3'd0, 8'hFF, "R1");
        look(4'd15, 0, 3'd0, 8'hFF, "R1");
    endtask

    task automatic t_target();
        look(4'd2, 1, 3'd3, 8'hF8, "R2");
        look(4'd2, 1, 3'd0, 8'hFF, "R2");
        look(4'd2, 1, 3'd7, 8'h80, "R2");
    endtask

    task automatic t_branch();
        @(negedge clk);
        upd_vld = 1'b1; upd_line_idx = 4'd4; upd_taken = 1'b1; upd_pos = 3'd2;
        look(4'd4, 0, 3'd0, 8'hFF, "R8");
        @(negedge clk);
        upd_vld = 1'b0;
        look(4'd4, 0, 3'd0, 8'h07, "R3");
        look(4'd5, 0, 3'd0, 8'hFF, "R7");
        look(4'd3, 0, 3'd0, 8'hFF, "R7");
    endtask

    task automatic t_both();
        look(4'd4, 1, 3'd1, 8'h06, "R4");
        look(4'd4, 1, 3'd2, 8'h04, "R4");
        look(4'd4, 1, 3'd5, 8'h20, "R5");
    endtask

    task automatic t_overwrite();
        upd(4'd4, 1'b1, 3'd6);
        look(4'd4, 0, 3'd0, 8'h7F, "R9");
        look(4'd4, 1, 3'd7, 8'h80, "R5");
    endtask

    task automatic t_clear();
        upd(4'd4, 1'b0, 3'd1);
        look(4'd4, 0, 3'd0, 8'hFF, "R6");
        look(4'd4, 1, 3'd7, 8'h80, "R6");
    endtask

    task automatic t_edges();
        upd(4'd9, 1'b1, 3'd7);
        look(4'd9, 0, 3'd0, 8'hFF, "R3");
        upd(4'd10, 1'b1, 3'd0);
        look(4'd10, 0, 3'd0, 8'h01, "R3");
        look(4'd10, 1, 3'd0, 8'h01, "R4");
        look(4'd10, 1, 3'd7, 8'h80, "R5");
        look(4'd9, 1, 3'd7, 8'h80, "R4");
        look(4'd11, 0, 3'd0, 8'hFF, "R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_target();
        t_branch();
        t_both();
        t_overwrite();
        t_clear();
        t_edges();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule